// File: doc/BRIEF.md
# HI/LO Multiply, Accumulate and Divide Unit

This execute-stage arithmetic unit computes every result that lands in the 64-bit HI/LO register pair. It handles signed and unsigned full-width multiply, a low-word multiply for a general register, multiply-accumulate and multiply-subtract against the current HI/LO value, and signed and unsigned division. The HI/LO registers are outside the unit. Their current contents arrive on `hi_in`/`lo_in`. The unit returns new values together with a single write enable, which the surrounding pipeline uses to update the registers.

Single-cycle multiplies are fully combinational. Accumulate operations take two cycles. In the first cycle the unit raises `stall_req` and registers the product. In the second cycle it applies the product to the HI/LO value. Division is a restoring divider that does one quotient bit per cycle and keeps `stall_req` high until it finishes. The unit never writes HI/LO in a cycle where the pipeline is stalled from elsewhere. Because of this, every result is applied exactly once.

A small state machine sequences the work. Its states are IDLE, ACC (second accumulate cycle), DIV (division iterations) and DONE (division result presented). IDLE goes to ACC when an accumulate starts. IDLE goes to DIV when a division with a non-zero divisor starts. ACC returns to IDLE once `stall_in` is low. DIV goes to DONE after DW iterations, or back to IDLE on `annul`. DONE returns to IDLE once `stall_in` is low or on `annul`.

Top module: `hilo_arith_unit`

## Requirements
- R1: With `start` high in IDLE, op code 1 (signed) or 2 (unsigned) drives `hilo_we` high in that same cycle. HI is set to the upper DW bits of the 2*DW-bit product of `src_a` and `src_b`, and LO to the lower DW bits.
- R2: Op code 3 puts the lower DW bits of the product on `low_result` in the start cycle and keeps `hilo_we` low. `low_result` is zero for every other op code.
- R3: Op codes 4 (signed) and 5 (unsigned) add the product to {HI,LO}. Op codes 6 (signed) and 7 (unsigned) subtract it, modulo 2^(2*DW). `stall_req` is high in the start cycle only, and the write happens in the following cycle.
- R4: While `stall_in` is high in the second accumulate cycle, the unit holds that cycle without writing. It writes exactly once, in the first such cycle where `stall_in` is low.
- R5: `hilo_we` is never high in a cycle where `stall_in` is high, whatever the operation or state.
- R6: Op codes 8 (signed) and 9 (unsigned) with a non-zero divisor hold `stall_req` high for DW+1 cycles from the start cycle. The result is written in the cycle after that, with the remainder in HI and the quotient in LO.
- R7: Signed division truncates the quotient toward zero, and the remainder takes the sign of the dividend. The most negative dividend divided by minus one yields a quotient of the most negative value.
- R8: A division whose divisor is zero completes in its start cycle with no `stall_req`. It writes the dividend to HI and all ones to LO.
- R9: `annul` during a division (DIV or DONE) suppresses the HI/LO write and returns the unit to IDLE. A new operation is accepted in the next cycle.
- R10: During and right after reset, `hilo_we` and `stall_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | An operation is present in the execute stage |
| op | input | 4 | Operation code |
| src_a | input | DW | First operand / dividend |
| src_b | input | DW | Second operand / divisor |
| hi_in | input | DW | Current HI value |
| lo_in | input | DW | Current LO value |
| stall_in | input | 1 | Stall from another pipeline source |
| annul | input | 1 | Abort an in-progress division |
| hilo_we | output | 1 | Write enable for HI and LO |
| hi_out | output | DW | New HI value |
| lo_out | output | DW | New LO value |
| low_result | output | DW | Low word of the product for the general register |
| stall_req | output | 1 | Stall request while a multi-cycle operation runs |

## Verification
The assertions assume that the pipeline behaves in two ways. First, it holds `start`, `op` and the operands steady while `stall_req` is high. Second, it feeds `hi_in`/`lo_in` from registers that update only when `hilo_we` fires. The bench models HI/LO as such a register and keeps every operation's inputs constant until the unit stops requesting a stall. It raises `stall_in` only in the accumulate second cycle, the divide result cycle and an idle multiply, and it pulses `annul` only while a division is running.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

    typedef enum logic [3:0] {
        OP_NONE  = 4'd0,
        OP_MULT  = 4'd1,
        OP_MULTU = 4'd2,
        OP_MUL   = 4'd3,
        OP_MADD  = 4'd4,
        OP_MADDU = 4'd5,
        OP_MSUB  = 4'd6,
        OP_MSUBU = 4'd7,
        OP_DIV   = 4'd8,
        OP_DIVU  = 4'd9
    } hilo_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACC,
        ST_DIV,
        ST_DONE
    } hilo_state_e;

endpackage

// File: rtl/hilo_mul.sv
module hilo_mul #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic            sgn,
    output logic [2*DW-1:0] prod
);
    localparam int PW = 2 * DW;

    logic [PW-1:0] ax;
    logic [PW-1:0] bx;

    // Extending both operands to full product width makes the truncated
    // product correct for both signed and unsigned interpretations.
    always_comb begin
        ax   = {{DW{sgn & a[DW-1]}}, a};
        bx   = {{DW{sgn & b[DW-1]}}, b};
        prod = ax * bx;
    end
endmodule

// File: rtl/hilo_div.sv
module hilo_div #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [DW-1:0] dvd_mag,
    input  logic [DW-1:0] dvs_mag,
    output logic [DW-1:0] quot,
    output logic [DW-1:0] rem
);
    logic [DW-1:0] q_r;
    logic [DW-1:0] r_r;
    logic [DW-1:0] d_r;
    logic [DW:0]   shifted;
    logic [DW:0]   diff;
    logic          fits;

    // One restoring step: bring in the next dividend bit, subtract if possible.
    always_comb begin
        shifted = {r_r, q_r[DW-1]};
        diff    = shifted - {1'b0, d_r};
        fits    = (shifted >= {1'b0, d_r});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= '0;
            r_r <= '0;
            d_r <= '0;
        end else if (load) begin
            q_r <= dvd_mag;
            r_r <= '0;
            d_r <= dvs_mag;
        end else if (step) begin
            if (fits) begin
                r_r <= diff[DW-1:0];
                q_r <= {q_r[DW-2:0], 1'b1};
            end else begin
                r_r <= shifted[DW-1:0];
                q_r <= {q_r[DW-2:0], 1'b0};
            end
        end
    end

    assign quot = q_r;
    assign rem  = r_r;
endmodule

// File: rtl/hilo_ctrl.sv
module hilo_ctrl
    import hilo_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go_acc,
    input  logic        go_div,
    input  logic        stall_in,
    input  logic        annul,
    output hilo_state_e state,
    output logic        acc_latch,
    output logic        div_load,
    output logic        div_step
);
    localparam int          CW   = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    hilo_state_e   nxt;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (div_load) cnt <= '0;
        else if (div_step) cnt <= cnt + 1'b1;
    end

    always_comb begin
        nxt       = state;
        acc_latch = 1'b0;
        div_load  = 1'b0;
        div_step  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (go_acc) begin
                    acc_latch = 1'b1;
                    nxt       = ST_ACC;
                end else if (go_div) begin
                    div_load = 1'b1;
                    nxt      = ST_DIV;
                end
            end
            ST_ACC: begin
                if (!stall_in) nxt = ST_IDLE;
            end
            ST_DIV: begin
                div_step = 1'b1;
                if (annul)            nxt = ST_IDLE;
                else if (cnt == LAST) nxt = ST_DONE;
            end
            ST_DONE: begin
                if (annul || !stall_in) nxt = ST_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/hilo_arith_unit.sv
module hilo_arith_unit
    import hilo_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    op,
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    input  logic [DW-1:0] hi_in,
    input  logic [DW-1:0] lo_in,
    input  logic          stall_in,
    input  logic          annul,
    output logic          hilo_we,
    output logic [DW-1:0] hi_out,
    output logic [DW-1:0] lo_out,
    output logic [DW-1:0] low_result,
    output logic          stall_req
);
    localparam int PW = 2 * DW;

    hilo_op_e    op_e;
    hilo_state_e fsm_state;

    logic is_mult, is_low, is_acc, is_div;
    logic mul_sgn, acc_sub, div_sgn, div_zero;
    logic a_neg, b_neg;
    logic [DW-1:0] mag_a, mag_b;
    logic [PW-1:0] prod, prod_q, base, acc_res;
    logic          sub_q, neg_q, neg_r;
    logic          acc_latch, div_load, div_step;
    logic [DW-1:0] quot, rem;

    assign op_e = hilo_op_e'(op);

    always_comb begin
        is_mult  = (op_e == OP_MULT) || (op_e == OP_MULTU);
        is_low   = (op_e == OP_MUL);
        is_acc   = (op_e == OP_MADD) || (op_e == OP_MADDU) ||
                   (op_e == OP_MSUB) || (op_e == OP_MSUBU);
        is_div   = (op_e == OP_DIV) || (op_e == OP_DIVU);
        mul_sgn  = (op_e == OP_MULT) || (op_e == OP_MUL) ||
                   (op_e == OP_MADD) || (op_e == OP_MSUB);
        acc_sub  = (op_e == OP_MSUB) || (op_e == OP_MSUBU);
        div_sgn  = (op_e == OP_DIV);
        div_zero = (src_b == '0);
        a_neg    = div_sgn & src_a[DW-1];
        b_neg    = div_sgn & src_b[DW-1];
        mag_a    = a_neg ? (~src_a + 1'b1) : src_a;
        mag_b    = b_neg ? (~src_b + 1'b1) : src_b;
    end

    hilo_mul #(.DW(DW)) u_mul (
        .a    (src_a),
        .b    (src_b),
        .sgn  (mul_sgn),
        .prod (prod)
    );

    hilo_ctrl #(.DW(DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_acc    (start && is_acc),
        .go_div    (start && is_div && !div_zero),
        .stall_in  (stall_in),
        .annul     (annul),
        .state     (fsm_state),
        .acc_latch (acc_latch),
        .div_load  (div_load),
        .div_step  (div_step)
    );

    hilo_div #(.DW(DW)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (div_load),
        .step    (div_step),
        .dvd_mag (mag_a),
        .dvs_mag (mag_b),
        .quot    (quot),
        .rem     (rem)
    );

    // Operation context kept across the multi-cycle sequences.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_q <= '0;
            sub_q  <= 1'b0;
            neg_q  <= 1'b0;
            neg_r  <= 1'b0;
        end else begin
            if (acc_latch) begin
                prod_q <= prod;
                sub_q  <= acc_sub;
            end
            if (div_load) begin
                neg_q <= a_neg ^ b_neg;
                neg_r <= a_neg;
            end
        end
    end

    always_comb begin
        base    = {hi_in, lo_in};
        acc_res = sub_q ? (base - prod_q) : (base + prod_q);
    end

    always_comb begin
        hilo_we    = 1'b0;
        hi_out     = hi_in;
        lo_out     = lo_in;
        low_result = '0;
        stall_req  = 1'b0;
        unique case (fsm_state)
            ST_IDLE: begin
                if (start) begin
                    if (is_mult) begin
                        hilo_we          = !stall_in;
                        {hi_out, lo_out} = prod;
                    end else if (is_low) begin
                        low_result = prod[DW-1:0];
                    end else if (is_acc) begin
                        stall_req = 1'b1;
                    end else if (is_div) begin
                        if (div_zero) begin
                            hilo_we = !stall_in;
                            hi_out  = src_a;
                            lo_out  = '1;
                        end else begin
                            stall_req = 1'b1;
                        end
                    end
                end
            end
            ST_ACC: begin
                hilo_we          = !stall_in;
                {hi_out, lo_out} = acc_res;
            end
            ST_DIV: begin
                stall_req = 1'b1;
            end
            ST_DONE: begin
                hilo_we = !stall_in && !annul;
                hi_out  = neg_r ? (~rem + 1'b1) : rem;
                lo_out  = neg_q ? (~quot + 1'b1) : quot;
            end
        endcase
    end
endmodule

// File: rtl/hilo_arith_chk.sv
module hilo_arith_chk
    import hilo_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [3:0]  op,
    input logic        stall_in,
    input logic        annul,
    input logic        hilo_we,
    input logic        stall_req,
    input hilo_state_e state
);
    logic acc_op;
    assign acc_op = (op == OP_MADD) || (op == OP_MADDU) ||
                    (op == OP_MSUB) || (op == OP_MSUBU);

    assert_low_word_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && op == OP_MUL) |-> !hilo_we);

    assert_acc_two_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && acc_op) |-> (stall_req && !hilo_we) ##1 (state == ST_ACC && !stall_req));

    assert_acc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACC && stall_in) |=> (state == ST_ACC));

    assert_acc_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACC && hilo_we) |=> (state != ST_ACC));

    assert_no_write_stalled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall_in |-> !hilo_we);

    assert_div_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DIV) |-> (stall_req && !hilo_we));

    assert_annul_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (annul && (state == ST_DIV || state == ST_DONE)) |-> !hilo_we);

    assert_annul_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (annul && (state == ST_DIV || state == ST_DONE)) |=> (state == ST_IDLE));
endmodule

bind hilo_arith_unit hilo_arith_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op        (op),
    .stall_in  (stall_in),
    .annul     (annul),
    .hilo_we   (hilo_we),
    .stall_req (stall_req),
    .state     (fsm_state)
);

// File: tb/tb_hilo_arith_unit.sv
module tb_hilo_arith_unit;
    import hilo_pkg::*;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [3:0]    op = 4'd0;
    logic [DW-1:0] src_a = '0, src_b = '0;
    logic [DW-1:0] hi_reg, lo_reg;
    logic          stall_in = 1'b0, annul = 1'b0;
    logic          hilo_we, stall_req;
    logic [DW-1:0] hi_out, lo_out, low_result;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    hilo_arith_unit #(.DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .src_a(src_a), .src_b(src_b), .hi_in(hi_reg), .lo_in(lo_reg),
        .stall_in(stall_in), .annul(annul), .hilo_we(hilo_we),
        .hi_out(hi_out), .lo_out(lo_out), .low_result(low_result),
        .stall_req(stall_req)
    );

    // Bench-side HI/LO registers, updated only by the write enable.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_reg <= '0;
            lo_reg <= '0;
        end else if (hilo_we) begin
            hi_reg <= hi_out;
            lo_reg <= lo_out;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic longint val(input logic [7:0] v, input bit sgn);
        return (sgn && v[7]) ? longint'(v) - 256 : longint'(v);
    endfunction

    function automatic logic [15:0] exp_prod(input logic [7:0] a, input logic [7:0] b, input bit sgn);
        longint p;
        p = val(a, sgn) * val(b, sgn);
        return p[15:0];
    endfunction

    function automatic logic [15:0] exp_div(input logic [7:0] a, input logic [7:0] b, input bit sgn);
        longint x, y, q, r;
        if (b == 8'd0) return {a, 8'hFF};
        x = val(a, sgn);
        y = val(b, sgn);
        q = x / y;
        r = x % y;
        return {r[7:0], q[7:0]};
    endfunction

    task automatic do_op(input hilo_op_e o, input logic [7:0] a, input logic [7:0] b,
                         output int n, output logic [7:0] lowr);
        @(negedge clk);
        start = 1'b1; op = o; src_a = a; src_b = b; n = 0;
        #5;
        while (stall_req && n < 100) begin
            @(negedge clk);
            n++;
            #5;
        end
        lowr = low_result;
        @(negedge clk);
        start = 1'b0; op = OP_NONE;
    endtask

    logic [7:0] bset [10] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h07, 8'h55,
                              8'h7F, 8'h80, 8'hFE, 8'hFF};

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int n;
        logic [7:0] lr;
        logic [15:0] base, e;

        // R10: reset state
        repeat (2) @(negedge clk);
        #5;
        chk("R10 we in reset", {31'd0, hilo_we}, 32'd0);
        chk("R10 stall in reset", {31'd0, stall_req}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        #5;
        chk("R10 we after reset", {31'd0, hilo_we}, 32'd0);
        chk("R10 stall after reset", {31'd0, stall_req}, 32'd0);

        // R1: full multiply sweep, signed and unsigned
        for (int s = 0; s < 2; s++) begin
            for (int ai = 0; ai < 256; ai++) begin
                for (int bi = 0; bi < 10; bi++) begin
                    do_op(s == 0 ? OP_MULT : OP_MULTU, ai[7:0], bset[bi], n, lr);
                    e = exp_prod(ai[7:0], bset[bi], s == 0);
                    chk("R1 product", {16'd0, hi_reg, lo_reg}, {16'd0, e});
                    chk("R1 no stall", n, 0);
                end
            end
        end

        // R2: low-word multiply leaves HI/LO alone
        for (int ai = 0; ai < 256; ai += 3) begin
            for (int bi = 0; bi < 10; bi++) begin
                base = {hi_reg, lo_reg};
                do_op(OP_MUL, ai[7:0], bset[bi], n, lr);
                e = exp_prod(ai[7:0], bset[bi], 1'b1);
                chk("R2 low word", {24'd0, lr}, {24'd0, e[7:0]});
                chk("R2 hilo kept", {16'd0, hi_reg, lo_reg}, {16'd0, base});
            end
        end
        do_op(OP_MULTU, 8'd9, 8'd9, n, lr);
        chk("R2 low_result zero for other op", {24'd0, lr}, 32'd0);

        // R3: accumulate and subtract-accumulate, all four forms
        for (int k = 0; k < 4; k++) begin
            for (int ai = 0; ai < 256; ai += 5) begin
                for (int bi = 0; bi < 10; bi++) begin
                    hilo_op_e o;
                    o = hilo_op_e'(4 + k);
                    base = {hi_reg, lo_reg};
                    do_op(o, ai[7:0], bset[bi], n, lr);
                    e = exp_prod(ai[7:0], bset[bi], (k == 0) || (k == 2));
                    e = (k >= 2) ? base - e : base + e;
                    chk("R3 accumulate", {16'd0, hi_reg, lo_reg}, {16'd0, e});
                    chk("R3 one stall cycle", n, 1);
                end
            end
        end

        // R4/R5: external stall during the second accumulate cycle
        base = {hi_reg, lo_reg};
        @(negedge clk);
        start = 1'b1; op = OP_MADD; src_a = 8'hF3; src_b = 8'h21;
        #5 chk("R4 first cycle stall", {31'd0, stall_req}, 32'd1);
        @(negedge clk); stall_in = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #5 chk("R4 held no write", {31'd0, hilo_we}, 32'd0);
            @(negedge clk);
        end
        stall_in = 1'b0;
        #5 chk("R4 write once released", {31'd0, hilo_we}, 32'd1);
        @(negedge clk); start = 1'b0; op = OP_NONE;
        e = base + exp_prod(8'hF3, 8'h21, 1'b1);
        chk("R4 applied once", {16'd0, hi_reg, lo_reg}, {16'd0, e});

        // R5: multiply under stall writes nothing
        base = {hi_reg, lo_reg};
        @(negedge clk);
        start = 1'b1; op = OP_MULTU; src_a = 8'h12; src_b = 8'h34; stall_in = 1'b1;
        #5 chk("R5 mult stalled", {31'd0, hilo_we}, 32'd0);
        @(negedge clk); start = 1'b0; op = OP_NONE; stall_in = 1'b0;
        #5 chk("R5 hilo kept", {16'd0, hi_reg, lo_reg}, {16'd0, base});

        // R5: division result held by stall
        @(negedge clk);
        start = 1'b1; op = OP_DIVU; src_a = 8'd200; src_b = 8'd7;
        repeat (DW + 1) @(negedge clk);
        stall_in = 1'b1;
        #5 chk("R5 done stalled", {31'd0, hilo_we}, 32'd0);
        @(negedge clk);
        #5 chk("R5 done still stalled", {31'd0, hilo_we}, 32'd0);
        @(negedge clk); stall_in = 1'b0;
        #5 chk("R5 done released", {31'd0, hilo_we}, 32'd1);
        @(negedge clk); start = 1'b0; op = OP_NONE;
        chk("R5 div result", {16'd0, hi_reg, lo_reg}, {16'd0, exp_div(8'd200, 8'd7, 1'b0)});

        // R6/R7/R8: division sweep
        for (int s = 0; s < 2; s++) begin
            for (int ai = 0; ai < 256; ai++) begin
                for (int bi = 0; bi < 10; bi++) begin
                    do_op(s == 0 ? OP_DIV : OP_DIVU, ai[7:0], bset[bi], n, lr);
                    e = exp_div(ai[7:0], bset[bi], s == 0);
                    if (bset[bi] == 8'd0) begin
                        chk("R8 zero divisor result", {16'd0, hi_reg, lo_reg}, {16'd0, e});
                        chk("R8 zero divisor no stall", n, 0);
                    end else if (s == 0) begin
                        chk("R7 signed div", {16'd0, hi_reg, lo_reg}, {16'd0, e});
                        chk("R6 stall length", n, DW + 1);
                    end else begin
                        chk("R6 unsigned div", {16'd0, hi_reg, lo_reg}, {16'd0, e});
                        chk("R6 stall length", n, DW + 1);
                    end
                end
            end
        end

        // R9: annul mid-division, then a new op right away
        base = {hi_reg, lo_reg};
        @(negedge clk);
        start = 1'b1; op = OP_DIVU; src_a = 8'd250; src_b = 8'd3;
        repeat (3) @(negedge clk);
        annul = 1'b1;
        #5 chk("R9 no write on annul", {31'd0, hilo_we}, 32'd0);
        @(negedge clk);
        annul = 1'b0; op = OP_MULTU; src_a = 8'd11; src_b = 8'd13;
        #5 chk("R9 idle after annul", {31'd0, stall_req}, 32'd0);
        chk("R9 new op accepted", {31'd0, hilo_we}, 32'd1);
        @(negedge clk); start = 1'b0; op = OP_NONE;
        chk("R9 result is new op", {16'd0, hi_reg, lo_reg}, {16'd0, exp_prod(8'd11, 8'd13, 1'b0)});

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule